// File: doc/BRIEF.md
# Watchpoint Comparator Unit

This block observes three buses from a processor core: the fetch address, the load/store address and the load/store data. Each bus has its own valid strobe. Eight programmable comparators are fixed to these buses. Comparators 0 to 3 watch the fetch address, 4 and 5 watch the load/store address, and 6 and 7 watch the load/store data. Each comparator holds a reference value, one of four unsigned relations and an enable bit.

The comparator hits are combined into six watchpoint outputs. Four are fetch watchpoints and two are load/store watchpoints. Any watchpoint can be joined with a partner comparator through an AND, so a window such as `lo < addr < hi` can be caught. Each watchpoint can also request a breakpoint. A per-watchpoint countdown holds the request back until a programmed number of matches has been seen. All settings are written through a single-cycle write port.

Top module: `dbg_watch_unit`

## Requirements
- R1: After reset, `wp_o`, `brk_req_o` and `brk_src_o` are zero. All comparators are disabled, and all break enables, pair bits and counts are zero.
- R2: The comparator relation code is 0 = equal, 1 = not equal, 2 = bus < reference, 3 = bus > reference. All comparisons are unsigned.
- R3: A comparator whose enable bit is clear never hits, whatever its reference and relation.
- R4: A comparator hits only in a cycle where the valid strobe of its bus is high. The resulting watchpoint value appears on `wp_o` one clock after that cycle.
- R5: Comparators 0–3 compare `iaddr_i`, comparators 4–5 compare `daddr_i`, and comparators 6–7 compare `ddata_i`.
- R6: Watchpoint k (k = 0..3) is comparator k. If its pair bit is set, it is comparator k AND comparator k XOR 1. Watchpoint 4+j (j = 0..1) is comparator 4+j. If its pair bit is set, it is comparator 4+j AND comparator 6+j.
- R7: `brk_src_o[k]` can be set only when the break enable bit of watchpoint k is set, and only in the same cycle that `wp_o[k]` is set. `brk_req_o` is the OR of `brk_src_o`.
- R8: With count N, a watchpoint with break enabled raises its break source on the (N+1)-th match. The counter then reloads N. A count of 0 raises the break source on every match.
- R9: A write to a watchpoint control register loads that watchpoint's counter. A match in the same cycle as the write is not counted and raises no break source, although `wp_o` still shows the match.
- R10: The write map (`cfg_addr_i`) is as follows. Address k (0–7) holds the reference of comparator k. Address 8+k holds comparator control: bits [1:0] relation, bit 2 enable. Address 16+k (k = 0–5) holds watchpoint control: bit 0 break enable, bit 1 pair, bits [15:8] count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 5 | Configuration register address |
| cfg_wdata_i | input | 32 | Configuration write data |
| iaddr_i | input | 32 | Fetch address |
| iaddr_vld_i | input | 1 | Fetch address valid |
| daddr_i | input | 32 | Load/store address |
| daddr_vld_i | input | 1 | Load/store address valid |
| ddata_i | input | 32 | Load/store data |
| ddata_vld_i | input | 1 | Load/store data valid |
| wp_o | output | 6 | Watchpoint flags: [3:0] fetch, [5:4] load/store |
| brk_req_o | output | 1 | Breakpoint request pulse |
| brk_src_o | output | 6 | Watchpoints that raised the request |

## Verification
A write to a watchpoint's control register and a counted match on that same watchpoint can fall in the same cycle. The bench provokes this by issuing the control write while the fetch bus carries an address that hits. It then judges three things. First, `wp_o` still reports the match. Second, no break source appears in that cycle. Third, the countdown that follows starts from the newly written count, so the next break comes after exactly that many further matches.

// File: rtl/dbg_watch_pkg.sv
package dbg_watch_pkg;
  typedef enum logic [1:0] {
    OP_EQ = 2'd0,
    OP_NE = 2'd1,
    OP_LT = 2'd2,
    OP_GT = 2'd3
  } cmp_op_e;

  typedef struct packed {
    logic    en;
    cmp_op_e op;
  } cmp_ctl_t;

  localparam int N_CMP    = 8;
  localparam int N_IW     = 4;
  localparam int N_DW     = 2;
  localparam int N_WP     = N_IW + N_DW;
  localparam int AW       = 5;
  localparam int REF_BASE = 0;
  localparam int CTL_BASE = 8;
  localparam int WP_BASE  = 16;
  localparam int CNT_LSB  = 8;
endpackage

// File: rtl/dbg_cmp.sv
module dbg_cmp
  import dbg_watch_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ref_we_i,
  input  logic          ctl_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] bus_i,
  input  logic          vld_i,
  output logic          hit_o
);
  logic [DW-1:0] ref_q;
  cmp_ctl_t      ctl_q;
  logic          rel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= '0;
      ctl_q <= '0;
    end else begin
      if (ref_we_i) ref_q <= wdata_i;
      if (ctl_we_i) ctl_q <= cmp_ctl_t'(wdata_i[2:0]);
    end
  end

  always_comb begin
    unique case (ctl_q.op)
      OP_EQ:   rel = (bus_i == ref_q);
      OP_NE:   rel = (bus_i != ref_q);
      OP_LT:   rel = (bus_i <  ref_q);
      default: rel = (bus_i >  ref_q);
    endcase
  end

  assign hit_o = ctl_q.en & vld_i & rel;
endmodule

// File: rtl/dbg_evt_cnt.sv
module dbg_evt_cnt #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          hit_i,
  output logic          fire_o
);
  logic [CW-1:0] reload_q, cnt_q;

  // a load cycle swallows any match in that cycle
  assign fire_o = hit_i & ~load_i & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      cnt_q    <= '0;
    end else if (load_i) begin
      reload_q <= load_val_i;
      cnt_q    <= load_val_i;
    end else if (hit_i) begin
      cnt_q <= (cnt_q == '0) ? reload_q : cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/dbg_watch_unit.sv
module dbg_watch_unit
  import dbg_watch_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [AW-1:0]     cfg_addr_i,
  input  logic [DW-1:0]     cfg_wdata_i,
  input  logic [DW-1:0]     iaddr_i,
  input  logic              iaddr_vld_i,
  input  logic [DW-1:0]     daddr_i,
  input  logic              daddr_vld_i,
  input  logic [DW-1:0]     ddata_i,
  input  logic              ddata_vld_i,
  output logic [N_WP-1:0]   wp_o,
  output logic              brk_req_o,
  output logic [N_WP-1:0]   brk_src_o
);
  logic [N_CMP-1:0] hit;
  logic [N_WP-1:0]  wp_hit, wp_we, fire, brk_en_q, pair_q;
  logic [N_WP-1:0]  wp_q, src_q;

  for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
    logic [DW-1:0] bus;
    logic          vld;
    if (k < N_IW) begin : g_i
      assign bus = iaddr_i;
      assign vld = iaddr_vld_i;
    end else if (k < N_IW + N_DW) begin : g_da
      assign bus = daddr_i;
      assign vld = daddr_vld_i;
    end else begin : g_dd
      assign bus = ddata_i;
      assign vld = ddata_vld_i;
    end
    dbg_cmp #(.DW(DW)) u_cmp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ref_we_i(cfg_we_i && cfg_addr_i == AW'(REF_BASE + k)),
      .ctl_we_i(cfg_we_i && cfg_addr_i == AW'(CTL_BASE + k)),
      .wdata_i (cfg_wdata_i),
      .bus_i   (bus),
      .vld_i   (vld),
      .hit_o   (hit[k])
    );
  end

  for (genvar k = 0; k < N_WP; k++) begin : g_wp
    localparam int PARTNER = (k < N_IW) ? (k ^ 1) : (k + N_DW);
    assign wp_we[k]  = cfg_we_i && cfg_addr_i == AW'(WP_BASE + k);
    assign wp_hit[k] = hit[k] & (~pair_q[k] | hit[PARTNER]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        brk_en_q[k] <= 1'b0;
        pair_q[k]   <= 1'b0;
      end else if (wp_we[k]) begin
        brk_en_q[k] <= cfg_wdata_i[0];
        pair_q[k]   <= cfg_wdata_i[1];
      end
    end

    dbg_evt_cnt #(.CW(CW)) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (wp_we[k]),
      .load_val_i(cfg_wdata_i[CNT_LSB +: CW]),
      .hit_i     (wp_hit[k] & brk_en_q[k]),
      .fire_o    (fire[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q      <= '0;
      src_q     <= '0;
      brk_req_o <= 1'b0;
    end else begin
      wp_q      <= wp_hit;
      src_q     <= fire;
      brk_req_o <= |fire;
    end
  end

  assign wp_o      = wp_q;
  assign brk_src_o = src_q;
endmodule

// File: rtl/dbg_watch_chk.sv
module dbg_watch_chk
  import dbg_watch_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cfg_we_i,
  input logic [AW-1:0]   cfg_addr_i,
  input logic            iaddr_vld_i,
  input logic            daddr_vld_i,
  input logic            ddata_vld_i,
  input logic [N_WP-1:0] wp_o,
  input logic            brk_req_o,
  input logic [N_WP-1:0] brk_src_o
);
  assert_idle_no_wp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(iaddr_vld_i | daddr_vld_i | ddata_vld_i) |=> wp_o == '0);

  assert_fetch_needs_ivld_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iaddr_vld_i |=> wp_o[N_IW-1:0] == '0);

  assert_ls_needs_dvld_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !daddr_vld_i |=> wp_o[N_WP-1:N_IW] == '0);

  assert_src_within_wp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_src_o & ~wp_o) == '0);

  assert_req_has_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_req_o |-> brk_src_o != '0);

  for (genvar k = 0; k < N_WP; k++) begin : g_ld
    assert_load_blocks_fire_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_we_i && cfg_addr_i == AW'(WP_BASE + k)) |=> !brk_src_o[k]);
  end
endmodule

bind dbg_watch_unit dbg_watch_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .cfg_addr_i (cfg_addr_i),
  .iaddr_vld_i(iaddr_vld_i),
  .daddr_vld_i(daddr_vld_i),
  .ddata_vld_i(ddata_vld_i),
  .wp_o       (wp_o),
  .brk_req_o  (brk_req_o),
  .brk_src_o  (brk_src_o)
);

// File: tb/sim_dbg_watch_unit.sv
`timescale 1ns/1ps
module sim_dbg_watch_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [4:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] iaddr_i = '0, daddr_i = '0, ddata_i = '0;
  logic        iaddr_vld_i = 1'b0, daddr_vld_i = 1'b0, ddata_vld_i = 1'b0;
  logic [5:0]  wp_o, brk_src_o;
  logic        brk_req_o;

  int n_chk = 0, n_fail = 0;

  typedef struct {
    string      tag;
    logic [5:0] wp;
    logic [5:0] src;
  } exp_t;
  exp_t sb[$];

  always #4 clk_i = ~clk_i;

  dbg_watch_unit u0 (.*);

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expectation queued for the monitor
  task automatic cyc(string tag, logic we, logic [4:0] a, logic [31:0] d,
                     logic [31:0] ia, logic iv, logic [31:0] da, logic dav,
                     logic [31:0] dd, logic ddv, logic [5:0] ewp, logic [5:0] esrc);
    exp_t e;
    @(negedge clk_i);
    cfg_we_i = we; cfg_addr_i = a; cfg_wdata_i = d;
    iaddr_i = ia; iaddr_vld_i = iv;
    daddr_i = da; daddr_vld_i = dav;
    ddata_i = dd; ddata_vld_i = ddv;
    e.tag = tag; e.wp = ewp; e.src = esrc;
    sb.push_back(e);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    cyc("R10", 1'b1, a, d, '0, 1'b0, '0, 1'b0, '0, 1'b0, 6'b0, 6'b0);
  endtask

  task automatic fetch(string tag, logic [31:0] ia, logic [5:0] ewp, logic [5:0] esrc);
    cyc(tag, 1'b0, '0, '0, ia, 1'b1, '0, 1'b0, '0, 1'b0, ewp, esrc);
  endtask

  // monitor
  initial begin
    forever begin
      exp_t e;
      @(posedge clk_i);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        check(e.tag, "wp_o", {26'b0, wp_o}, {26'b0, e.wp});
        check(e.tag, "brk_src_o", {26'b0, brk_src_o}, {26'b0, e.src});
        check(e.tag, "brk_req_o", {31'b0, brk_req_o}, {31'b0, |e.src});
      end
    end
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", "wp_o", {26'b0, wp_o}, 32'd0);
    check("R1", "brk_req_o", {31'b0, brk_req_o}, 32'd0);
    rst_ni = 1'b1;
    // R3: all comparators disabled, reference 0 would match under EQ
    cyc("R3", 1'b0, '0, '0, '0, 1'b1, '0, 1'b1, '0, 1'b1, 6'b0, 6'b0);
    // R2 equal
    wr(5'd0, 32'h1000); wr(5'd8, 32'h4);
    fetch("R2", 32'h1000, 6'b000001, 6'b0);
    cyc("R4", 1'b0, '0, '0, 32'h1000, 1'b0, '0, 1'b0, '0, 1'b0, 6'b0, 6'b0);
    // R2 not-equal
    wr(5'd1, 32'h5); wr(5'd9, 32'h5);
    fetch("R2", 32'h1000, 6'b000011, 6'b0);
    fetch("R2", 32'h5, 6'b000000, 6'b0);
    // R2 less / greater, unsigned
    wr(5'd2, 32'h80); wr(5'd10, 32'h6);
    wr(5'd3, 32'h10); wr(5'd11, 32'h7);
    fetch("R2", 32'h20, 6'b001110, 6'b0);
    fetch("R2", 32'hFFFF_FFFF, 6'b001010, 6'b0);
    fetch("R2", 32'h80, 6'b001010, 6'b0);
    fetch("R2", 32'h10, 6'b000110, 6'b0);
    // R6 fetch pairing: wp2 = cmp2 & cmp3
    wr(5'd18, 32'h2);
    fetch("R6", 32'h20, 6'b001110, 6'b0);
    fetch("R6", 32'h10, 6'b000010, 6'b0);
    // R5 data comparators
    wr(5'd4, 32'h2000); wr(5'd12, 32'h4);
    wr(5'd6, 32'h100);  wr(5'd14, 32'h7);
    wr(5'd13, 32'h5);
    cyc("R5", 1'b0, '0, '0, '0, 1'b0, 32'h2000, 1'b1, '0, 1'b0, 6'b110000, 6'b0);
    fetch("R5", 32'h2000, 6'b001010, 6'b0);
    // R6 load/store pairing: wp4 = cmp4 & cmp6
    wr(5'd20, 32'h2);
    cyc("R6", 1'b0, '0, '0, '0, 1'b0, 32'h2000, 1'b1, 32'h50, 1'b1, 6'b100000, 6'b0);
    cyc("R6", 1'b0, '0, '0, '0, 1'b0, 32'h2000, 1'b1, 32'h200, 1'b1, 6'b110000, 6'b0);
    cyc("R4", 1'b0, '0, '0, '0, 1'b0, 32'h2000, 1'b1, 32'h200, 1'b0, 6'b100000, 6'b0);
    // R8 count 0 on wp0: every match
    wr(5'd16, 32'h1);
    fetch("R8", 32'h1000, 6'b001011, 6'b000001);
    fetch("R8", 32'h1000, 6'b001011, 6'b000001);
    // R8 count 2 on wp1: every third match, reload
    wr(5'd17, 32'h201);
    fetch("R8", 32'h20, 6'b001110, 6'b0);
    fetch("R8", 32'h20, 6'b001110, 6'b0);
    fetch("R8", 32'h5, 6'b000000, 6'b0);
    fetch("R8", 32'h20, 6'b001110, 6'b000010);
    fetch("R8", 32'h20, 6'b001110, 6'b0);
    fetch("R8", 32'h20, 6'b001110, 6'b0);
    fetch("R8", 32'h20, 6'b001110, 6'b000010);
    fetch("R8", 32'h20, 6'b001110, 6'b0);
    // R9 write with a match in the same cycle: no fire, counter from new value
    cyc("R9", 1'b1, 5'd17, 32'h101, 32'h20, 1'b1, '0, 1'b0, '0, 1'b0, 6'b001110, 6'b0);
    fetch("R9", 32'h20, 6'b001110, 6'b0);
    fetch("R9", 32'h20, 6'b001110, 6'b000010);
    // R7 break disabled
    wr(5'd17, 32'h0);
    fetch("R7", 32'h20, 6'b001110, 6'b0);
    cyc("R4", 1'b0, '0, '0, '0, 1'b0, '0, 1'b0, '0, 1'b0, 6'b0, 6'b0);
    repeat (3) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule